// File: doc/BRIEF.md
# Privilege-Filtered CSR Access Unit

This block holds the machine-level status, interrupt-enable, interrupt-pending and interrupt-delegation registers of a 32-bit core that runs in machine and user mode. It decodes a 12-bit CSR address and checks that the requested access is allowed at the current privilege level. Reads return their data in the same cycle. Writes take effect at the next clock edge. Any access that is refused raises an error flag in the same cycle, and that refused access changes no state.

There is only one physical copy of the status, enable and pending registers. Each one appears at several addresses, called aliases, and the privilege field of the address selects the mask that the alias applies. The pending register also takes hardware request lines. The timer-pending bit comes only from hardware. The instruction-set description word and the two halves of an external time value are readable but not writable.

Top module: `csr_priv_unit`

## Requirements
- R1: Address bits [9:8] give the privilege the access needs (U=0, S=1, M=3). A read or write where that value is greater than `cur_priv` raises `csr_err` and changes no state.
- R2: The status register at 0x000 reads as the stored value AND 0x80000011. A write there changes only those bits.
- R3: The status register at 0x300 reads as the stored value AND 0x807FF9DD. A write there changes only those bits, so stored bits outside 0x807FF9DD are always zero.
- R4: The enable register is at 0x004, 0x104 and 0x304. A write updates only the bits in 0x111, 0x333 or 0xBBB respectively. Every other stored bit keeps its old value.
- R5: The pending register is at 0x044, 0x144 and 0x344 and uses the same per-alias write masks as R4, except that bit 7 is never software-writable. Each clock, bit 7 copies `hw_pend[7]`. Any other set bit of `hw_pend` sets the matching stored bit, and that bit stays set.
- R6: Reads of the enable and pending registers return the stored value AND the delegation register. The delegation register is at 0x303 and is a full 32-bit read/write register.
- R7: Address 0x301 reads as parameter `ISA_VAL`. Address 0xC01 reads `ext_time[31:0]` and 0xC81 reads `ext_time[63:32]`. A write to any of these three raises `csr_err`.
- R8: After reset, the status, enable, pending and delegation registers are all zero.
- R9: An address with no register raises `csr_err`, returns zero read data and changes no state.
- R10: A read and a write in the same cycle return the value from before the write. The new value is visible from the next cycle.
- R11: With neither strobe set, `csr_err` is 0 and `csr_rdata` is 0. `csr_rdata` is also 0 whenever `csr_err` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_priv | input | 2 | Current privilege level (U=0, S=1, M=3) |
| csr_addr | input | 12 | CSR address |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| hw_pend | input | 12 | Hardware interrupt request lines |
| ext_time | input | 64 | External time value, readable through the time addresses |
| csr_rdata | output | 32 | Read data, same cycle |
| csr_err | output | 1 | Access refused: privilege, unknown address or read-only write |

## Verification
Some properties are checked by assertions on every cycle:
- a privilege denial always raises the error flag;
- a refused access leaves status, enable and delegation unchanged;
- the timer-pending bit follows the hardware line one cycle later;
- no stored status or enable bit ever lies outside the widest mask;
- the idle outputs are zero.

Other properties depend on a sequence of accesses, and only the bench's scenarios can show them. A behavioural model in the bench checks:
- the per-alias masks;
- that unmasked bits survive a narrow write;
- that delegation gates the read value;
- that hardware pending bits stay set;
- the old-value return of a combined read and write.

// File: rtl/csr_priv_unit.sv
module csr_priv_unit #(
  parameter logic [31:0] ISA_VAL = 32'h4010_1100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cur_priv,
  input  logic [11:0] csr_addr,
  input  logic        csr_rd,
  input  logic        csr_wr,
  input  logic [31:0] csr_wdata,
  input  logic [11:0] hw_pend,
  input  logic [63:0] ext_time,
  output logic [31:0] csr_rdata,
  output logic        csr_err
);
  localparam logic [31:0] ST_U = 32'h8000_0011;
  localparam logic [31:0] ST_M = 32'h807F_F9DD;
  localparam logic [31:0] IRQ_ALL = 32'h0000_0BBB;
  localparam logic [31:0] HW_ONLY = 32'h0000_0080;

  logic [31:0] stat_q, ie_q, ip_q, deleg_q;
  logic [31:0] stat_m, irq_m, rd_val, ip_nxt;

  wire access = csr_rd | csr_wr;
  wire [1:0] need = csr_addr[9:8];
  wire priv_ok = need <= cur_priv;

  wire is_stat  = csr_addr == 12'h000 || csr_addr == 12'h300;
  wire is_ie    = csr_addr == 12'h004 || csr_addr == 12'h104 || csr_addr == 12'h304;
  wire is_ip    = csr_addr == 12'h044 || csr_addr == 12'h144 || csr_addr == 12'h344;
  wire is_deleg = csr_addr == 12'h303;
  wire is_isa   = csr_addr == 12'h301;
  wire is_tlo   = csr_addr == 12'hC01;
  wire is_thi   = csr_addr == 12'hC81;
  wire is_ro    = is_isa | is_tlo | is_thi;
  wire known    = is_stat | is_ie | is_ip | is_deleg | is_ro;

  assign csr_err = access & (~known | ~priv_ok | (csr_wr & is_ro));
  wire do_wr = csr_wr & ~csr_err;

  assign stat_m = (need == 2'd0) ? ST_U : ST_M;

  always_comb begin
    case (need)
      2'd0:    irq_m = 32'h111;
      2'd1:    irq_m = 32'h333;
      2'd3:    irq_m = 32'hBBB;
      default: irq_m = 32'h0;
    endcase
  end

  always_comb begin
    rd_val = '0;
    if (is_stat)       rd_val = stat_q & stat_m;
    else if (is_ie)    rd_val = ie_q & deleg_q;
    else if (is_ip)    rd_val = ip_q & deleg_q;
    else if (is_deleg) rd_val = deleg_q;
    else if (is_isa)   rd_val = ISA_VAL;
    else if (is_tlo)   rd_val = ext_time[31:0];
    else if (is_thi)   rd_val = ext_time[63:32];
  end

  assign csr_rdata = (csr_rd & ~csr_err) ? rd_val : '0;

  always_comb begin
    ip_nxt = ip_q;
    if (do_wr && is_ip)
      ip_nxt = (ip_q & ~(irq_m & ~HW_ONLY)) | (csr_wdata & irq_m & ~HW_ONLY);
    ip_nxt = (ip_nxt & ~HW_ONLY) | {20'b0, hw_pend};
    ip_nxt[7] = hw_pend[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      ie_q    <= '0;
      ip_q    <= '0;
      deleg_q <= '0;
    end else begin
      ip_q <= ip_nxt;
      if (do_wr && is_stat)  stat_q  <= (stat_q & ~stat_m) | (csr_wdata & stat_m);
      if (do_wr && is_ie)    ie_q    <= (ie_q & ~irq_m) | (csr_wdata & irq_m);
      if (do_wr && is_deleg) deleg_q <= csr_wdata;
    end
  end

  // R1
  priv_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access && (csr_addr[9:8] > cur_priv)) |-> csr_err);

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_err |=> ($stable(stat_q) && $stable(ie_q) && $stable(deleg_q)));

  // R5
  mtip_hw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ip_q[7] == $past(hw_pend[7])));

  // R3
  stat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~ST_M) == 32'h0);

  // R4
  ie_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q & ~IRQ_ALL) == 32'h0);

  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!access || csr_err) |-> (csr_rdata == 32'h0));
endmodule

// File: tb/sim_csr_priv_unit.sv
module sim_csr_priv_unit;
  localparam logic [31:0] ISA = 32'h4010_1100;
  localparam logic [63:0] TIMEV = 64'h0000_0123_89AB_CDEF;

  logic clk = 0, rst_n = 0;
  logic [1:0] cur_priv = 2'd3;
  logic [11:0] csr_addr = '0, hw_pend = '0;
  logic csr_rd = 0, csr_wr = 0;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic csr_err;
  logic [63:0] ext_time = TIMEV;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_stat = 0, m_ie = 0, m_ip = 0, m_deleg = 0;

  always #5 clk = ~clk;

  csr_priv_unit #(.ISA_VAL(ISA)) u0 (
    .clk(clk), .rst_n(rst_n), .cur_priv(cur_priv), .csr_addr(csr_addr),
    .csr_rd(csr_rd), .csr_wr(csr_wr), .csr_wdata(csr_wdata), .hw_pend(hw_pend),
    .ext_time(ext_time), .csr_rdata(csr_rdata), .csr_err(csr_err));

  function automatic logic [31:0] wmask(input logic [11:0] a);
    case (a)
      12'h000: return 32'h8000_0011;
      12'h300: return 32'h807F_F9DD;
      12'h004, 12'h044: return 32'h111;
      12'h104, 12'h144: return 32'h333;
      12'h304, 12'h344: return 32'hBBB;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic op(input logic [1:0] p, input logic [11:0] a, input bit r, input bit w,
                    input logic [31:0] d, input logic [11:0] hw, input string tag);
    bit known, ro, e;
    logic [31:0] val, expd;
    @(negedge clk);
    cur_priv = p; csr_addr = a; csr_rd = r; csr_wr = w; csr_wdata = d; hw_pend = hw;
    #4;
    known = 1; ro = 0; val = 0;
    case (a)
      12'h000, 12'h300: val = m_stat & wmask(a);
      12'h004, 12'h104, 12'h304: val = m_ie & m_deleg;
      12'h044, 12'h144, 12'h344: val = m_ip & m_deleg;
      12'h303: val = m_deleg;
      12'h301: begin val = ISA; ro = 1; end
      12'hC01: begin val = TIMEV[31:0]; ro = 1; end
      12'hC81: begin val = TIMEV[63:32]; ro = 1; end
      default: known = 0;
    endcase
    e = (r || w) && (!known || (a[9:8] > p) || (w && ro));
    expd = (r && !e) ? val : 32'h0;
    tests++;
    if (csr_err !== e || csr_rdata !== expd) begin
      fails++;
      $display("FAIL %s: addr=%h err=%b rdata=%h expected err=%b rdata=%h",
               tag, a, csr_err, csr_rdata, e, expd);
    end
    @(posedge clk);
    if (w && !e) begin
      case (a)
        12'h000, 12'h300: m_stat = (m_stat & ~wmask(a)) | (d & wmask(a));
        12'h004, 12'h104, 12'h304: m_ie = (m_ie & ~wmask(a)) | (d & wmask(a));
        12'h044, 12'h144, 12'h344:
          m_ip = (m_ip & ~(wmask(a) & ~32'h80)) | (d & wmask(a) & ~32'h80);
        12'h303: m_deleg = d;
        default: ;
      endcase
    end
    m_ip = m_ip | {20'b0, hw};
    m_ip[7] = hw[7];
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R8 reset state
    op(3, 12'h300, 1, 0, 0, 0, "R8");
    op(3, 12'h304, 1, 0, 0, 0, "R8");
    op(3, 12'h344, 1, 0, 0, 0, "R8");
    op(3, 12'h303, 1, 0, 0, 0, "R8");
    // R6 delegation gates reads
    op(3, 12'h304, 0, 1, 32'hFFFF_FFFF, 0, "R4");
    op(3, 12'h304, 1, 0, 0, 0, "R6");
    op(3, 12'h303, 0, 1, 32'h0000_0FFF, 0, "R6");
    op(3, 12'h304, 1, 0, 0, 0, "R4");
    op(3, 12'h303, 0, 1, 32'h0000_0F0F, 0, "R6");
    op(3, 12'h304, 1, 0, 0, 0, "R6");
    op(3, 12'h303, 0, 1, 32'h0000_0FFF, 0, "R6");
    // R4 per-alias enable masks
    op(0, 12'h004, 0, 1, 32'h0, 0, "R4");
    op(0, 12'h004, 1, 0, 0, 0, "R4");
    op(3, 12'h104, 0, 1, 32'hFFFF_FFFF, 0, "R4");
    op(3, 12'h304, 1, 0, 0, 0, "R4");
    op(3, 12'h104, 0, 1, 32'h0, 0, "R4");
    op(3, 12'h304, 1, 0, 0, 0, "R4");
    // R3 / R2 status aliases
    op(3, 12'h300, 0, 1, 32'hFFFF_FFFF, 0, "R3");
    op(3, 12'h300, 1, 0, 0, 0, "R3");
    op(0, 12'h000, 1, 0, 0, 0, "R2");
    op(0, 12'h000, 0, 1, 32'h0, 0, "R2");
    op(3, 12'h300, 1, 0, 0, 0, "R2");
    op(0, 12'h000, 0, 1, 32'hFFFF_FFFF, 0, "R2");
    op(3, 12'h300, 1, 0, 0, 0, "R2");
    // R1 privilege denial
    op(0, 12'h300, 1, 1, 32'h0, 0, "R1");
    op(3, 12'h300, 1, 0, 0, 0, "R1");
    op(0, 12'h304, 0, 1, 32'h0, 0, "R1");
    op(0, 12'h303, 1, 0, 0, 0, "R1");
    op(3, 12'h304, 1, 0, 0, 0, "R1");
    // R9 unknown addresses
    op(3, 12'h100, 1, 1, 32'h0, 0, "R9");
    op(3, 12'h7C0, 0, 1, 32'h0, 0, "R9");
    op(3, 12'h340, 1, 0, 0, 0, "R9");
    op(3, 12'h300, 1, 0, 0, 0, "R9");
    // R7 read-only registers
    op(3, 12'h301, 1, 0, 0, 0, "R7");
    op(3, 12'h301, 1, 1, 32'h0, 0, "R7");
    op(0, 12'hC01, 1, 0, 0, 0, "R7");
    op(0, 12'hC81, 1, 0, 0, 0, "R7");
    op(3, 12'hC01, 0, 1, 32'h5, 0, "R7");
    // R5 pending register
    op(3, 12'h344, 0, 1, 32'hFFFF_FFFF, 0, "R5");
    op(3, 12'h344, 1, 0, 0, 0, "R5");
    op(3, 12'h344, 1, 0, 0, 12'h080, "R5");
    op(3, 12'h344, 0, 1, 32'h0, 12'h080, "R5");
    op(3, 12'h344, 1, 0, 0, 12'h000, "R5");
    op(3, 12'h344, 1, 0, 0, 12'h008, "R5");
    op(3, 12'h344, 1, 0, 0, 12'h000, "R5");
    op(0, 12'h044, 0, 1, 32'h0, 0, "R5");
    op(3, 12'h144, 0, 1, 32'hFFF, 0, "R5");
    op(3, 12'h344, 1, 0, 0, 0, "R5");
    op(0, 12'h044, 1, 0, 0, 0, "R5");
    // R10 read and write together
    op(3, 12'h303, 1, 1, 32'h0000_0FF0, 0, "R10");
    op(3, 12'h303, 1, 0, 0, 0, "R10");
    op(3, 12'h300, 1, 1, 32'h0, 0, "R10");
    op(3, 12'h300, 1, 0, 0, 0, "R10");
    // R11 idle
    op(3, 12'h300, 0, 0, 32'hFFFF_FFFF, 0, "R11");
    op(0, 12'h7C0, 0, 0, 32'h0, 0, "R11");
    op(3, 12'h300, 1, 0, 0, 0, "R11");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule